// File: doc/BRIEF.md
# Start-of-Payload Deframer With Acquisition Timeout

This block sits behind a preamble synchronizer in a pulse-position receiver. Once the synchronizer reports lock, exactly one bit decision arrives per symbol frame. The deframer watches that bit stream for the bitwise complement of the transmitter's 16-bit identification code. The complement marks where the packet data begins. Plain repeats of the code, which keep arriving while the preamble finishes, do not count as a marker.

After the marker, the block forwards the header bits and then the payload bits, one FIFO write per bit and in arrival order. The FIFO storage is outside the block. While the header passes, the block collects three copies of a packet index and resolves them with a bitwise two-of-three vote. It then presents the voted index with a one-cycle valid pulse.

If no marker appears within a programmable number of post-lock bits, the block declares a false acquisition. It pulses a flag that tells the synchronizer to resume its search, and then goes idle. When the last payload bit has been forwarded, the block pulses a done flag and also goes idle. A further lock is then needed to start the next packet.

Top module: `payload_deframer`

## Requirements
- R1: After reset, fifo_wr, false_acq, packet_done, overflow, index_valid and deframe_active are all 0, and pkt_index is 0.
- R2: While idle, bit_valid and bit_in are ignored and produce no FIFO writes. A one-cycle sync_lock pulse while idle starts the marker hunt, and deframe_active is 1 from the next clock edge.
- R3: The marker is found only when the last 16 bits accepted since lock equal ~id_code, with the earliest received of those bits as the MSB. Repeats of id_code, and a complement with any single bit wrong, do not start the header.
- R4: If the count of bits accepted since lock reaches timeout_bits without a marker, false_acq pulses for one cycle and the block goes idle. If the marker completes on the bit that reaches the limit, the marker wins and false_acq stays 0.
- R5: Each of the HDR_BITS + PAY_BITS bits that follow the marker produces one fifo_wr pulse on the cycle after it is accepted, with fifo_bit equal to that bit and in arrival order. Hunt and marker bits are never written.
- R6: Header offsets 0, 16 and 32 each start a 16-bit copy, MSB first. After the last header bit, pkt_index takes the bitwise 2-of-3 majority of the three copies, and index_valid pulses once per packet.
- R7: After the final payload bit, packet_done pulses for one cycle and deframe_active drops. No more bits are written until a new sync_lock.
- R8: overflow becomes 1 when fifo_wr is 1 while fifo_full is 1, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_lock | input | 1 | One-cycle pulse from the synchronizer when it acquires |
| bit_valid | input | 1 | A frame's bit decision is present on bit_in |
| bit_in | input | 1 | Bit decision |
| id_code | input | CODE_W | Transmitter identification code; the marker is its complement |
| timeout_bits | input | TO_W | Post-lock bit budget for finding the marker (64 covers four code repeats) |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_bit | output | 1 | Data bit for the FIFO write |
| overflow | output | 1 | Sticky: a write was issued while the FIFO was full |
| false_acq | output | 1 | One-cycle pulse: marker not found in time, resume acquisition |
| packet_done | output | 1 | One-cycle pulse: last payload bit forwarded |
| deframe_active | output | 1 | Block is hunting or forwarding |
| pkt_index | output | IDX_W | Majority-voted packet index |
| index_valid | output | 1 | One-cycle pulse when pkt_index is updated |

## Verification
The bench builds the block with HDR_BITS = 56 and PAY_BITS = 24 and keeps the 16-bit code and index. With these values a whole packet, and an exact FIFO stream for every packet, fit in a few hundred cycles. The 8 filler bits after the third index copy show that the vote reads fixed offsets and not the end of the header. The timeout is driven at 64 and at 48. At 48 the marker can complete exactly on the limit bit, and a corrupted marker can run into the budget.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_HDR  = 2'd2,
        ST_PAY  = 2'd3
    } dfr_state_e;

    typedef struct packed {
        logic wr;
        logic dat;
    } dfr_wr_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/deframer_marker.sv
module deframer_marker #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_in,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    localparam int FILL_W = $clog2(CODE_W + 1);

    logic [CODE_W-1:0] win;
    logic [CODE_W-1:0] win_nxt;
    logic [FILL_W-1:0] fill;
    logic              full_nxt;

    always_comb begin
        win_nxt  = {win[CODE_W-2:0], bit_in};
        full_nxt = (fill >= FILL_W'(CODE_W - 1));
        hit      = shift && full_nxt && (win_nxt == ~code);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            win  <= '0;
            fill <= '0;
        end else if (shift) begin
            win <= win_nxt;
            if (fill != FILL_W'(CODE_W))
                fill <= fill + FILL_W'(1);
        end
    end

endmodule

// File: rtl/deframer_index_vote.sv
module deframer_index_vote
    import deframer_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int POS_W = 10,
    parameter int OFF0  = 0,
    parameter int OFF1  = 16,
    parameter int OFF2  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [POS_W-1:0] pos,
    input  logic             bit_in,
    input  logic             vote,
    output logic [IDX_W-1:0] idx_out,
    output logic             idx_valid
);
    logic [2:0][IDX_W-1:0] copies;
    logic [IDX_W-1:0]      voted;

    for (genvar k = 0; k < 3; k++) begin : g_copy
        localparam int OFF = (k == 0) ? OFF0 : (k == 1) ? OFF1 : OFF2;
        logic [IDX_W-1:0] r;
        logic [POS_W:0]   rel;
        logic             in_win;

        always_comb begin
            rel    = {1'b0, pos} - (POS_W + 1)'(OFF);
            in_win = (rel < (POS_W + 1)'(IDX_W));
        end

        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (take && in_win)
                r <= {r[IDX_W-2:0], bit_in};
        end

        assign copies[k] = r;
    end

    for (genvar b = 0; b < IDX_W; b++) begin : g_vote
        assign voted[b] = maj3(copies[0][b], copies[1][b], copies[2][b]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_out   <= '0;
            idx_valid <= 1'b0;
        end else begin
            idx_valid <= vote;
            if (vote)
                idx_out <= voted;
        end
    end

endmodule

// File: rtl/payload_deframer.sv
module payload_deframer
    import deframer_pkg::*;
#(
    parameter int CODE_W   = 16,
    parameter int HDR_BITS = 144,
    parameter int PAY_BITS = 800,
    parameter int IDX_W    = 16,
    parameter int IDX_OFF0 = 0,
    parameter int IDX_OFF1 = 16,
    parameter int IDX_OFF2 = 32,
    parameter int TO_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_lock,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [CODE_W-1:0] id_code,
    input  logic [TO_W-1:0]   timeout_bits,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic              fifo_bit,
    output logic              overflow,
    output logic              false_acq,
    output logic              packet_done,
    output logic              deframe_active,
    output logic [IDX_W-1:0]  pkt_index,
    output logic              index_valid
);
    localparam int MAX_LEN = (HDR_BITS > PAY_BITS) ? HDR_BITS : PAY_BITS;
    localparam int POS_W   = $clog2(MAX_LEN);

    dfr_state_e        state;
    logic [TO_W-1:0]   post_cnt;
    logic [TO_W-1:0]   cnt_nxt;
    logic [POS_W-1:0]  pos;
    dfr_wr_t           wr_q;
    logic              vote_q;
    logic              hunt_take;
    logic              hdr_take;
    logic              marker_clear;
    logic              marker_hit;

    always_comb begin
        hunt_take    = bit_valid && (state == ST_HUNT);
        hdr_take     = bit_valid && (state == ST_HDR);
        marker_clear = sync_lock && (state == ST_IDLE);
        cnt_nxt      = post_cnt + TO_W'(1);
    end

    deframer_marker #(
        .CODE_W (CODE_W)
    ) u_marker (
        .clk    (clk),
        .rst    (rst),
        .clear  (marker_clear),
        .shift  (hunt_take),
        .bit_in (bit_in),
        .code   (id_code),
        .hit    (marker_hit)
    );

    deframer_index_vote #(
        .IDX_W (IDX_W),
        .POS_W (POS_W),
        .OFF0  (IDX_OFF0),
        .OFF1  (IDX_OFF1),
        .OFF2  (IDX_OFF2)
    ) u_vote (
        .clk       (clk),
        .rst       (rst),
        .take      (hdr_take),
        .pos       (pos),
        .bit_in    (bit_in),
        .vote      (vote_q),
        .idx_out   (pkt_index),
        .idx_valid (index_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            post_cnt    <= '0;
            pos         <= '0;
            wr_q        <= '0;
            vote_q      <= 1'b0;
            overflow    <= 1'b0;
            false_acq   <= 1'b0;
            packet_done <= 1'b0;
        end else begin
            wr_q.wr     <= 1'b0;
            vote_q      <= 1'b0;
            false_acq   <= 1'b0;
            packet_done <= 1'b0;
            if (wr_q.wr && fifo_full)
                overflow <= 1'b1;

            unique case (state)
                ST_IDLE: begin
                    if (sync_lock) begin
                        state    <= ST_HUNT;
                        post_cnt <= '0;
                    end
                end
                ST_HUNT: begin
                    if (bit_valid) begin
                        post_cnt <= cnt_nxt;
                        if (marker_hit) begin
                            state <= ST_HDR;
                            pos   <= '0;
                        end else if (cnt_nxt >= timeout_bits) begin
                            state     <= ST_IDLE;
                            false_acq <= 1'b1;
                        end
                    end
                end
                ST_HDR: begin
                    if (bit_valid) begin
                        wr_q.wr  <= 1'b1;
                        wr_q.dat <= bit_in;
                        if (pos == POS_W'(HDR_BITS - 1)) begin
                            state  <= ST_PAY;
                            pos    <= '0;
                            vote_q <= 1'b1;
                        end else begin
                            pos <= pos + POS_W'(1);
                        end
                    end
                end
                ST_PAY: begin
                    if (bit_valid) begin
                        wr_q.wr  <= 1'b1;
                        wr_q.dat <= bit_in;
                        if (pos == POS_W'(PAY_BITS - 1)) begin
                            state       <= ST_IDLE;
                            pos         <= '0;
                            packet_done <= 1'b1;
                        end else begin
                            pos <= pos + POS_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign fifo_wr        = wr_q.wr;
    assign fifo_bit       = wr_q.dat;
    assign deframe_active = (state != ST_IDLE);

endmodule

// File: rtl/deframer_checker.sv
module deframer_checker (
    input logic clk,
    input logic rst,
    input logic sync_lock,
    input logic bit_valid,
    input logic fifo_wr,
    input logic overflow,
    input logic false_acq,
    input logic packet_done,
    input logic deframe_active,
    input logic index_valid
);
    // R2: activity only begins after a lock request
    a_r2_start_on_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(deframe_active) |-> $past(sync_lock));

    // R5: every FIFO write answers an accepted bit
    a_r5_wr_follows_bit: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(bit_valid) && $past(deframe_active));

    // R4: false acquisition leaves the block idle
    a_r4_timeout_idles: assert property (@(posedge clk) disable iff (rst)
        false_acq |-> !deframe_active);

    // R7: end of payload leaves the block idle
    a_r7_done_idles: assert property (@(posedge clk) disable iff (rst)
        packet_done |-> !deframe_active);

    // R4 and R7 never coincide
    a_r7_not_with_timeout: assert property (@(posedge clk) disable iff (rst)
        !(packet_done && false_acq));

    // R6: the index is only voted inside a packet
    a_r6_vote_in_packet: assert property (@(posedge clk) disable iff (rst)
        index_valid |-> $past(deframe_active));

    // R8: overflow is sticky
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(overflow) |-> overflow);

endmodule

bind payload_deframer deframer_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .sync_lock      (sync_lock),
    .bit_valid      (bit_valid),
    .fifo_wr        (fifo_wr),
    .overflow       (overflow),
    .false_acq      (false_acq),
    .packet_done    (packet_done),
    .deframe_active (deframe_active),
    .index_valid    (index_valid)
);

// File: tb/sim_payload_deframer.sv
module sim_payload_deframer;
    localparam int CW = 16;
    localparam int HB = 56;
    localparam int PB = 24;
    localparam int IW = 16;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_lock = 1'b0;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic [CW-1:0] id_code = '0;
    logic [TW-1:0] timeout_bits = 16'd64;
    logic          fifo_full = 1'b0;
    logic          fifo_wr, fifo_bit, overflow, false_acq, packet_done;
    logic          deframe_active, index_valid;
    logic [IW-1:0] pkt_index;

    payload_deframer #(
        .CODE_W(CW), .HDR_BITS(HB), .PAY_BITS(PB), .IDX_W(IW),
        .IDX_OFF0(0), .IDX_OFF1(16), .IDX_OFF2(32), .TO_W(TW)
    ) u0 (
        .clk(clk), .rst(rst), .sync_lock(sync_lock), .bit_valid(bit_valid),
        .bit_in(bit_in), .id_code(id_code), .timeout_bits(timeout_bits),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_bit(fifo_bit),
        .overflow(overflow), .false_acq(false_acq), .packet_done(packet_done),
        .deframe_active(deframe_active), .pkt_index(pkt_index),
        .index_valid(index_valid)
    );

    always #4 clk = ~clk;

    int   checks = 0;
    int   errors = 0;
    int   wcount = 0;
    int   dcount = 0;
    int   facount = 0;
    int   ivcount = 0;
    logic cap [256];
    logic expb [HB+PB];

    always @(negedge clk) begin
        if (fifo_wr) begin
            cap[wcount % 256] = fifo_bit;
            wcount++;
        end
        if (packet_done) dcount++;
        if (false_acq)   facount++;
        if (index_valid) ivcount++;
    end

    // {code, copy0, copy1, copy2, expected index}
    localparam logic [79:0] VEC [4] = '{
        {16'h0013, 16'h1234, 16'h1234, 16'h1234, 16'h1234},
        {16'h0007, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF},
        {16'h002B, 16'hF0F0, 16'hCCCC, 16'hAAAA, 16'hE8E8},
        {16'h00E1, 16'h0000, 16'hFFFF, 16'h1357, 16'h1357}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic lock_pulse();
        @(negedge clk);
        sync_lock = 1'b1;
        @(negedge clk);
        sync_lock = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, d0, f0, iv0, mism;
        logic [15:0] code, a, b, c, ex;

        do_reset();
        // R1 reset state
        chk("R1 fifo_wr", fifo_wr, 0);
        chk("R1 false_acq", false_acq, 0);
        chk("R1 packet_done", packet_done, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 index_valid", index_valid, 0);
        chk("R1 active", deframe_active, 0);
        chk("R1 pkt_index", pkt_index, 0);

        // Table of packets
        for (int v = 0; v < 4; v++) begin
            code = VEC[v][79:64]; a = VEC[v][63:48]; b = VEC[v][47:32];
            c = VEC[v][31:16]; ex = VEC[v][15:0];
            id_code = code;
            timeout_bits = 16'd64;
            for (int i = 0; i < 16; i++) begin
                expb[i]      = a[15-i];
                expb[16 + i] = b[15-i];
                expb[32 + i] = c[15-i];
            end
            for (int i = 0; i < 8; i++) expb[48 + i] = 8'hA5 >> (7 - i);
            for (int i = 0; i < PB; i++) expb[HB + i] = code[i % 16] ^ (i % 3 == 0);
            base = wcount; d0 = dcount; f0 = facount; iv0 = ivcount;
            lock_pulse();
            send_word(code);
            send_word(code);
            send_word(~code);
            for (int i = 0; i < HB + PB; i++) send_bit(expb[i]);
            repeat (4) @(negedge clk);
            mism = 0;
            for (int i = 0; i < HB + PB; i++)
                if (cap[(base + i) % 256] !== expb[i]) mism++;
            chk("R5 write count", wcount - base, HB + PB);
            chk("R5 stream mismatches", mism, 0);
            chk("R6 voted index", pkt_index, ex);
            chk("R6 one index_valid", ivcount - iv0, 1);
            chk("R7 one packet_done", dcount - d0, 1);
            chk("R7 idle after payload", deframe_active, 0);
            chk("R3 no false acquisition", facount - f0, 0);
        end

        // R2: bits while idle are ignored
        id_code = 16'h0007;
        base = wcount;
        for (int i = 0; i < 20; i++) send_bit(i[0]);
        send_word(~16'h0007);
        repeat (2) @(negedge clk);
        chk("R2 idle bits not written", wcount - base, 0);
        chk("R2 stays idle", deframe_active, 0);
        lock_pulse();
        chk("R2 lock starts hunt", deframe_active, 1);

        // R4/R3: timeout at 64 with only code repeats
        timeout_bits = 16'd64;
        f0 = facount;
        send_word(16'h0007); send_word(16'h0007); send_word(16'h0007);
        for (int i = 15; i >= 1; i--) send_bit(id_code[i]);
        chk("R3 repeats ignored, still hunting", deframe_active, 1);
        chk("R4 no timeout before limit", facount - f0, 0);
        send_bit(id_code[0]);
        repeat (2) @(negedge clk);
        chk("R4 timeout pulse", facount - f0, 1);
        chk("R4 idle after timeout", deframe_active, 0);
        chk("R5 hunt bits not written", wcount - base, 0);

        // R3: marker with one wrong bit times out at 48
        timeout_bits = 16'd48;
        f0 = facount;
        lock_pulse();
        send_word(16'h0007); send_word(16'h0007);
        send_word(~16'h0007 ^ 16'h0010);
        repeat (2) @(negedge clk);
        chk("R3 near miss rejected", facount - f0, 1);
        chk("R3 near miss no writes", wcount - base, 0);

        // R4 marker on the limit bit wins; R8 overflow while full
        f0 = facount; d0 = dcount;
        lock_pulse();
        send_word(16'h0007); send_word(16'h0007);
        send_word(~16'h0007);
        fifo_full = 1'b1;
        for (int i = 0; i < HB + PB; i++) send_bit(1'b0);
        repeat (2) @(negedge clk);
        fifo_full = 1'b0;
        chk("R4 marker at limit wins", facount - f0, 0);
        chk("R4 packet completes", dcount - d0, 1);
        chk("R8 overflow set", overflow, 1);

        // R8 sticky across a clean packet, cleared by reset
        lock_pulse();
        send_word(~16'h0007);
        for (int i = 0; i < HB + PB; i++) send_bit(1'b1);
        repeat (2) @(negedge clk);
        chk("R8 overflow sticky", overflow, 1);
        do_reset();
        chk("R1 overflow cleared by reset", overflow, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule